// File: doc/BRIEF.md
# Super I/O configuration port

This block is the configuration front end of a legacy peripheral controller. A host issues byte reads and writes on an I/O address bus. Two consecutive addresses form an index/data pair. A strap input places the pair at 0x2E/0x2F or at 0x4E/0x4F. The register space starts out locked. It opens only after the host writes the enter key 0x87 to the index port twice in a row. Writing 0xAA to the index port locks it again.

Once the space is open, the host writes a register number into the index port and then reads or writes that register through the data port. Registers below 0x30 are global:

- a logical-device number at 0x07;
- a two-byte read-only identifier at 0x20 and 0x21;
- a pin-function register at 0x2C.

Registers at 0x30 and above belong to the logical device whose number is held at 0x07. Each device has an enable register at 0x30 and a small file of general registers starting at 0xE0. The block exports the pin-function code and one enable bit per device to the rest of the chip.

Top module: `sio_cfg_port`

## Requirements
- R1: The index port is at address 0x002E and the data port at 0x002F when `strap_hi_base` is 0. When it is 1, they are at 0x004E and 0x004F. Accesses at any other address have no effect, and a read there returns 0xFF.
- R2: `cfg_unlocked` rises in the cycle after the second of two consecutive index-port writes of 0x87, and never rises otherwise.
- R3: An index-port write of any value other than 0x87 after a single 0x87 returns the key sequence to its start, so 0x87, 0x12, 0x87 leaves the space locked.
- R4: While unlocked, an index-port write of 0xAA locks the space in the next cycle.
- R5: While locked, data-port writes change no register, and reads of either port return 0xFF.
- R6: While unlocked, a read of the index port returns the last index written while unlocked.
- R7: Index 0x20 reads 0xA2. Index 0x21 reads 0x3 in bits 7:4 and the revision parameter (default 1) in bits 3:0. Writes to both are ignored.
- R8: Index 0x07 is a read/write logical-device number. It selects which device's registers appear at indices 0x30 and above.
- R9: Index 0x2C is a read/write byte whose bits 1:0 drive `pin_func`. The codes are 0 for infrared off, 1 for infrared, 2 for general I/O bank 1 and 3 for the second serial port.
- R10: Each device n below NDEV has an enable register at 0x30, whose bit 0 drives `dev_enable[n]`, and NREG general registers at 0xE0 upward. The registers of different devices are independent.
- R11: With a logical-device number of NDEV or more, indices 0x30 and above read 0x00 and writes there have no effect.
- R12: Reads of unimplemented indices return 0x00, and writes to them have no effect.
- R13: Reset (synchronous, active low) locks the space and clears the index, the device number, the pin-function register and every device register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_hi_base | input | 1 | Selects the 0x4E/0x4F port pair when 1 |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe, one byte per cycle |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read data for the current cycle's read, 0xFF when nothing answers |
| cfg_unlocked | output | 1 | Register space is open |
| pin_func | output | 2 | Pin-function select code |
| dev_enable | output | NDEV | Enable bit of each logical device |

## Verification
The key logic is driven with a clean double key, with a key broken by a foreign byte, with keys sent to the wrong port pair, and with the exit key. These separate a sequencer that counts key bytes from one that demands consecutive ones, and one that decodes the strap from one that does not. Register access is tried with the same indices under different device numbers, including a number past the last device. This shows that the banks are separated and that the decode behaves out of range. Writes to identifier, unimplemented and locked locations are followed by reads and by a look at the exported pins, so that an ignored write can be told apart from a stored one.

// File: rtl/sio_cfg_pkg.sv
// Shared constants and types for the configuration port.
// Assumes an 8-bit register space addressed through an index register.
package sio_cfg_pkg;
    localparam logic [7:0] KEY_ENTER     = 8'h87;
    localparam logic [7:0] KEY_EXIT      = 8'hAA;
    localparam logic [7:0] IDX_LDN       = 8'h07;
    localparam logic [7:0] IDX_ID_HI     = 8'h20;
    localparam logic [7:0] IDX_ID_LO     = 8'h21;
    localparam logic [7:0] IDX_PINMUX    = 8'h2C;
    localparam logic [7:0] IDX_BANK_BASE = 8'h30;
    localparam logic [7:0] IDX_DEV_EN    = 8'h30;
    localparam logic [7:0] ID_HI_VALUE   = 8'hA2;
    localparam logic [3:0] ID_LO_FAMILY  = 4'h3;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_HALF   = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;
endpackage

// File: rtl/sio_key_seq.sv
// Unlock sequencer: opens the register space after two consecutive enter
// keys written to the index port, and closes it on the exit key.
// Assumes idx_wr pulses for one cycle per host write to the index port.
module sio_key_seq
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       unlocked
);
    key_state_e state_q;

    // Advance the key state on each index-port write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= KS_LOCKED;
        end else if (idx_wr) begin
            case (state_q)
                KS_LOCKED: state_q <= (wdata == KEY_ENTER) ? KS_HALF : KS_LOCKED;
                KS_HALF:   state_q <= (wdata == KEY_ENTER) ? KS_OPEN : KS_LOCKED;
                KS_OPEN:   if (wdata == KEY_EXIT) state_q <= KS_LOCKED;
                default:   state_q <= KS_LOCKED;
            endcase
        end
    end

    // Only the fully keyed state opens the space.
    assign unlocked = (state_q == KS_OPEN);
endmodule

// File: rtl/sio_global_regs.sv
// Global registers below the bank boundary: device number, identifier and
// pin-function select. Assumes wr_en is already qualified by unlock state.
module sio_global_regs
    import sio_cfg_pkg::*;
#(
    parameter logic [7:0] ID_LO = 8'h31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] ldn_q,
    output logic [7:0] pinmux_q,
    output logic [7:0] rd_data
);
    // Store writes to the writable global registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q    <= '0;
            pinmux_q <= '0;
        end else if (wr_en) begin
            if (idx == IDX_LDN)    ldn_q    <= wdata;
            if (idx == IDX_PINMUX) pinmux_q <= wdata;
        end
    end

    // Return the addressed global register, zero when unimplemented.
    always_comb begin
        case (idx)
            IDX_LDN:    rd_data = ldn_q;
            IDX_ID_HI:  rd_data = ID_HI_VALUE;
            IDX_ID_LO:  rd_data = ID_LO;
            IDX_PINMUX: rd_data = pinmux_q;
            default:    rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/sio_dev_bank.sv
// One logical device's registers: an enable byte and NREG general bytes.
// Assumes FILE_BASE lies above the enable index and FILE_BASE+NREG <= 256.
module sio_dev_bank
    import sio_cfg_pkg::*;
#(
    parameter int         NREG      = 4,
    parameter logic [7:0] FILE_BASE = 8'hE0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       wr_en,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    output logic [7:0] en_q,
    output logic [7:0] rd_data
);
    logic [7:0] file_q [NREG];

    // Store writes aimed at this device while it is selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            for (int i = 0; i < NREG; i++) file_q[i] <= '0;
        end else if (sel && wr_en) begin
            if (idx == IDX_DEV_EN) en_q <= wdata;
            for (int i = 0; i < NREG; i++)
                if (idx == FILE_BASE + 8'(i)) file_q[i] <= wdata;
        end
    end

    // Drive read data only while selected so banks can be OR-combined.
    always_comb begin
        rd_data = 8'h00;
        if (sel) begin
            if (idx == IDX_DEV_EN) rd_data = en_q;
            for (int i = 0; i < NREG; i++)
                if (idx == FILE_BASE + 8'(i)) rd_data = file_q[i];
        end
    end
endmodule

// File: rtl/sio_cfg_port.sv
// Index/data configuration port with key unlock and banked device registers.
// Assumes one host access per cycle and never a read and write together.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int                NDEV    = 4,
    parameter int                NREG    = 4,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = ADDR_W'(16'h002E),
    parameter logic [ADDR_W-1:0] BASE_HI = ADDR_W'(16'h004E),
    parameter logic [3:0]        REV     = 4'h1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_hi_base,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_unlocked,
    output logic [1:0]        pin_func,
    output logic [NDEV-1:0]   dev_enable
);
    localparam logic [7:0] ID_LO = {ID_LO_FAMILY, REV};

    logic [ADDR_W-1:0] base;
    logic              hit_idx, hit_dat, idx_wr, data_wr;
    logic [7:0]        idx_q, ldn_q, pinmux_q, glob_rd, bank_rd;
    logic              in_bank;
    logic [7:0]        bank_rd_v [NDEV];

    // Port pair decode from the strap.
    assign base    = strap_hi_base ? BASE_HI : BASE_LO;
    assign hit_idx = (io_addr == base);
    assign hit_dat = (io_addr == base + ADDR_W'(1));
    assign idx_wr  = io_wr && hit_idx;
    assign data_wr = io_wr && hit_dat && cfg_unlocked;
    assign in_bank = (idx_q >= IDX_BANK_BASE);

    sio_key_seq u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (io_wdata),
        .unlocked (cfg_unlocked)
    );

    // Capture the register index while the space is open.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          idx_q <= '0;
        else if (cfg_unlocked && idx_wr && io_wdata != KEY_EXIT) idx_q <= io_wdata;
    end

    sio_global_regs #(.ID_LO(ID_LO)) u_glob (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (data_wr && !in_bank),
        .idx      (idx_q),
        .wdata    (io_wdata),
        .ldn_q    (ldn_q),
        .pinmux_q (pinmux_q),
        .rd_data  (glob_rd)
    );

    generate
        for (genvar d = 0; d < NDEV; d++) begin : g_dev
            logic [7:0] en_q;
            sio_dev_bank #(.NREG(NREG), .FILE_BASE(8'hE0)) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .sel     (ldn_q == 8'(d)),
                .wr_en   (data_wr && in_bank),
                .idx     (idx_q),
                .wdata   (io_wdata),
                .en_q    (en_q),
                .rd_data (bank_rd_v[d])
            );
            assign dev_enable[d] = en_q[0];
        end
    endgenerate

    // Merge bank read data; unselected banks contribute zero.
    always_comb begin
        bank_rd = 8'h00;
        for (int d = 0; d < NDEV; d++) bank_rd = bank_rd | bank_rd_v[d];
    end

    // Host read mux: 0xFF when locked or when nothing is addressed.
    always_comb begin
        io_rdata = 8'hFF;
        if (io_rd && cfg_unlocked) begin
            if (hit_idx)      io_rdata = idx_q;
            else if (hit_dat) io_rdata = in_bank ? bank_rd : glob_rd;
        end
    end

    assign pin_func = pinmux_q[1:0];
endmodule

// File: rtl/sio_cfg_port_chk.sv
// Property checker for the configuration port, bound to every instance.
// Assumes the same parameter defaults as the top module.
module sio_cfg_port_chk #(
    parameter int                NDEV    = 4,
    parameter int                ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE_LO = ADDR_W'(16'h002E),
    parameter logic [ADDR_W-1:0] BASE_HI = ADDR_W'(16'h004E)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              strap_hi_base,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_wr,
    input logic              io_rd,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_unlocked,
    input logic [1:0]        pin_func,
    input logic [NDEV-1:0]   dev_enable
);
    logic [ADDR_W-1:0] c_base;
    logic              c_idx, c_dat;
    assign c_base = strap_hi_base ? BASE_HI : BASE_LO;
    assign c_idx  = (io_addr == c_base);
    assign c_dat  = (io_addr == c_base + ADDR_W'(1));

    // R2: opening only follows an index-port enter key
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_unlocked) |-> $past(io_wr && c_idx && io_wdata == 8'h87));

    // R4: exit key closes the space
    a_r4_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_unlocked && io_wr && c_idx && io_wdata == 8'hAA) |=> !cfg_unlocked);

    // R5: locked reads return all ones
    a_r5_locked_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_unlocked && io_rd) |-> (io_rdata == 8'hFF));

    // R9: pin function moves only on a data-port write
    a_r9_pinfunc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && c_dat) |=> $stable(pin_func));

    // R10: device enables move only on a data-port write
    a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && c_dat) |=> $stable(dev_enable));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
    .NDEV(NDEV), .ADDR_W(ADDR_W), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_hi_base (strap_hi_base),
    .io_addr       (io_addr),
    .io_wr         (io_wr),
    .io_rd         (io_rd),
    .io_wdata      (io_wdata),
    .io_rdata      (io_rdata),
    .cfg_unlocked  (cfg_unlocked),
    .pin_func      (pin_func),
    .dev_enable    (dev_enable)
);

// File: tb/tb_sio_cfg_port.sv
// Bench: behavioural reference model compared every cycle plus directed checks.
module tb_sio_cfg_port;
    localparam int ND = 4;
    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_unlocked;
    logic [1:0]  pin_func;
    logic [ND-1:0] dev_enable;

    int n_tests = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sio_cfg_port dut (
        .clk(clk), .rst_n(rst_n), .strap_hi_base(strap), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_unlocked(cfg_unlocked), .pin_func(pin_func), .dev_enable(dev_enable)
    );

    // Reference model state
    int         m_stage;
    logic [7:0] m_idx, m_ldn, m_mux;
    logic [7:0] m_en [ND];
    logic [7:0] m_file [ND][NR];

    function automatic logic [15:0] base_of();
        return strap ? 16'h004E : 16'h002E;
    endfunction

    function automatic logic [7:0] m_read();
        if (!io_rd || m_stage != 2) return 8'hFF;
        if (io_addr == base_of()) return m_idx;
        if (io_addr != base_of() + 16'd1) return 8'hFF;
        if (m_idx < 8'h30) begin
            if (m_idx == 8'h07) return m_ldn;
            if (m_idx == 8'h20) return 8'hA2;
            if (m_idx == 8'h21) return 8'h31;
            if (m_idx == 8'h2C) return m_mux;
            return 8'h00;
        end
        if (m_ldn >= ND) return 8'h00;
        if (m_idx == 8'h30) return m_en[m_ldn];
        if (m_idx >= 8'hE0 && m_idx < 8'hE0 + NR) return m_file[m_ldn][m_idx - 8'hE0];
        return 8'h00;
    endfunction

    // Model update on each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0; m_idx = 0; m_ldn = 0; m_mux = 0;
            for (int d = 0; d < ND; d++) begin
                m_en[d] = 0;
                for (int r = 0; r < NR; r++) m_file[d][r] = 0;
            end
        end else if (io_wr && io_addr == base_of()) begin
            if (m_stage == 0)      m_stage = (io_wdata == 8'h87) ? 1 : 0;
            else if (m_stage == 1) m_stage = (io_wdata == 8'h87) ? 2 : 0;
            else if (io_wdata == 8'hAA) m_stage = 0;
            else m_idx = io_wdata;
        end else if (io_wr && io_addr == base_of() + 16'd1 && m_stage == 2) begin
            if (m_idx < 8'h30) begin
                if (m_idx == 8'h07) m_ldn = io_wdata;
                if (m_idx == 8'h2C) m_mux = io_wdata;
            end else if (m_ldn < ND) begin
                if (m_idx == 8'h30) m_en[m_ldn] = io_wdata;
                if (m_idx >= 8'hE0 && m_idx < 8'hE0 + NR) m_file[m_ldn][m_idx - 8'hE0] = io_wdata;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    // Model comparison away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [ND-1:0] exp_en;
            for (int d = 0; d < ND; d++) exp_en[d] = m_en[d][0];
            chk("R5 model io_rdata", io_rdata, m_read());
            chk("R2 model cfg_unlocked", cfg_unlocked, m_stage == 2);
            chk("R9 model pin_func", pin_func, m_mux[1:0]);
            chk("R10 model dev_enable", dev_enable, exp_en);
        end
    end

    task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        io_addr = a; io_wdata = d; io_wr = 1'b1; io_rd = 1'b0;
        @(posedge clk); #1;
        io_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [15:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        io_addr = a; io_rd = 1'b1; io_wr = 1'b0;
        @(negedge clk);
        v = io_rdata;
        @(posedge clk); #1;
        io_rd = 1'b0;
    endtask

    task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
        bus_wr(base_of(), i);
        bus_wr(base_of() + 16'd1, d);
    endtask

    task automatic cfg_rd(input logic [7:0] i, output logic [7:0] v);
        bus_wr(base_of(), i);
        bus_rd(base_of() + 16'd1, v);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R13 reset state
        chk("R13 unlocked after reset", cfg_unlocked, 0);
        chk("R13 pin_func after reset", pin_func, 0);
        chk("R13 dev_enable after reset", dev_enable, 0);

        // R5 locked access
        bus_rd(16'h002F, v);  chk("R5 locked data read", v, 8'hFF);
        bus_wr(16'h002F, 8'h03);
        chk("R5 locked write ignored", pin_func, 0);

        // R3 broken key
        bus_wr(16'h002E, 8'h87); bus_wr(16'h002E, 8'h12); bus_wr(16'h002E, 8'h87);
        chk("R3 broken key stays locked", cfg_unlocked, 0);
        bus_wr(16'h002E, 8'h87);
        chk("R3 key after restart opens", cfg_unlocked, 1);

        // R6 index readback
        bus_wr(16'h002E, 8'h2C);
        bus_rd(16'h002E, v); chk("R6 index readback", v, 8'h2C);

        // R9 pin function
        bus_wr(16'h002F, 8'h02);
        chk("R9 pin_func code 2", pin_func, 2);
        cfg_wr(8'h2C, 8'hF3);
        chk("R9 pin_func code 3", pin_func, 3);
        cfg_rd(8'h2C, v); chk("R9 full byte readback", v, 8'hF3);

        // R7 identifier
        cfg_rd(8'h20, v); chk("R7 id high", v, 8'hA2);
        cfg_wr(8'h21, 8'h00);
        cfg_rd(8'h21, v); chk("R7 id low read-only", v, 8'h31);

        // R12 unimplemented global index
        cfg_wr(8'h25, 8'h5A);
        cfg_rd(8'h25, v); chk("R12 unimplemented global reads 0", v, 8'h00);
        cfg_rd(8'h2C, v); chk("R12 write elsewhere left 0x2C", v, 8'hF3);

        // R8 and R10 banking
        cfg_wr(8'h07, 8'h01);
        cfg_wr(8'h30, 8'h01);
        chk("R10 device 1 enable", dev_enable, 4'b0010);
        cfg_wr(8'hE0, 8'h11);
        cfg_wr(8'h07, 8'h02);
        cfg_wr(8'hE0, 8'h22);
        cfg_wr(8'h30, 8'h01);
        chk("R10 device 2 enable", dev_enable, 4'b0110);
        cfg_rd(8'hE0, v); chk("R10 device 2 file", v, 8'h22);
        cfg_wr(8'h07, 8'h01);
        cfg_rd(8'hE0, v); chk("R8 device 1 file kept", v, 8'h11);
        cfg_rd(8'h07, v); chk("R8 device number readback", v, 8'h01);
        cfg_rd(8'hE5, v); chk("R12 unimplemented bank index", v, 8'h00);

        // R11 out-of-range device
        cfg_wr(8'h07, 8'h07);
        cfg_wr(8'h30, 8'h01);
        chk("R11 enables unchanged", dev_enable, 4'b0110);
        cfg_rd(8'hE0, v); chk("R11 out-of-range file reads 0", v, 8'h00);
        cfg_rd(8'h30, v); chk("R11 out-of-range enable reads 0", v, 8'h00);

        // R4 exit key
        bus_wr(16'h002E, 8'hAA);
        chk("R4 exit key locks", cfg_unlocked, 0);
        bus_rd(16'h002E, v); chk("R5 locked index read", v, 8'hFF);

        // R2 plain unlock
        bus_wr(16'h002E, 8'h87);
        chk("R2 one key stays locked", cfg_unlocked, 0);
        bus_wr(16'h002E, 8'h87);
        chk("R2 two keys open", cfg_unlocked, 1);
        bus_wr(16'h002E, 8'hAA);

        // R1 alternate base
        strap = 1'b1;
        bus_wr(16'h002E, 8'h87); bus_wr(16'h002E, 8'h87);
        chk("R1 old base ignored", cfg_unlocked, 0);
        bus_wr(16'h004E, 8'h87); bus_wr(16'h004E, 8'h87);
        chk("R1 high base opens", cfg_unlocked, 1);
        bus_wr(16'h004E, 8'h20);
        bus_rd(16'h004F, v); chk("R1 high base data port", v, 8'hA2);
        bus_rd(16'h002F, v); chk("R1 off-window read", v, 8'hFF);

        // R13 reset mid-run
        @(posedge clk); #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk("R13 relocked by reset", cfg_unlocked, 0);
        chk("R13 pin_func cleared", pin_func, 0);
        chk("R13 enables cleared", dev_enable, 0);

        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule